// File: doc/BRIEF.md
# Maskable Vectored Interrupt Controller

This block gathers the interrupt sources of a small 4-bit microcontroller and turns them into a single request to the CPU core. There are three sources from the clock timer, for 2 Hz, 8 Hz and 32 Hz ticks. A fourth source is a group of four input pins. Each timer source has its own event flag, and a falling edge of its tick sets that flag. The four pins each have their own enable bit but share one event flag. A rising edge on any enabled pin sets the shared flag. Software reads the flags through a small register port, and any read of a flag register clears every flag that the register holds.

A request goes to the core only when a flag is set, its mask allows it, and the global enable is on. When the core acknowledges a pending request, the controller does three things. It latches a page-one vector that names the pending source class, it clears the global enable, and it marks a fixed-length entry window in which the core saves its return address and loads the vector. Software turns the global enable on again with an enable command, or turns it off with a disable command.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, every flag, every mask and the global enable are 0, `irq_req` and `entry_busy` are 0, `aux_ctl` is 0, `irq_vector` is 0x100, and reads of 0x075, 0x078, 0x079 and 0x07A return 0.
- R2: A falling edge of a timer tick (high in one cycle, low in the next) sets that tick's flag on the clock edge that samples the low level. A rising edge sets nothing. Register 0x079 shows the flags: bit 2 is the 2 Hz flag, bit 1 the 8 Hz flag, bit 0 the 32 Hz flag.
- R3: A rising edge on pin n sets the shared pin flag, bit 2 of 0x07A, only when bit n of 0x075 is 1. A rising edge on a pin whose mask bit is 0 does not set the flag, and neither does a falling edge on any pin.
- R4: A read returns the flags as they stood before the read. A read of 0x079 clears all three timer flags, and a read of 0x07A clears the pin flag. Writes to 0x079 and 0x07A have no effect. Bits without a function, and any address outside the map, read as 0.
- R5: When a flag's set edge falls in the same cycle as a read that clears that flag, the flag is still 1 after that cycle.
- R6: The mask registers can be written and read back. 0x075 bits 3..0 are the pin masks. 0x078 bits 2..0 are the 2 Hz, 8 Hz and 32 Hz masks, and 0x078 bit 3 is a separate control bit that drives `aux_ctl`.
- R7: `irq_req` is 1 exactly when the global enable is 1, no entry window is open, and either some timer flag has its mask bit set or the pin flag is set while at least one pin mask bit is set. It follows the flags and masks within the same cycle.
- R8: `ei_cmd` sets the global enable and `di_cmd` clears it, each on the next clock edge. A flag that was never cleared raises `irq_req` again once the enable is set.
- R9: `irq_ack` while `irq_req` is 1 clears the global enable. It also latches `irq_vector`: 0x102 for a pin request only, 0x104 for a timer request only, and 0x106 for both. `entry_busy` is then 1 for exactly 12 cycles, starting on the next edge.
- R10: `irq_ack` while `irq_req` is 0 has no effect: `entry_busy` stays 0 and `irq_vector` keeps its value. `irq_vector` does not change while `entry_busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_2hz | input | 1 | 2 Hz timer tick level |
| tick_8hz | input | 1 | 8 Hz timer tick level |
| tick_32hz | input | 1 | 32 Hz timer tick level |
| port_pins | input | 4 | Raw input pin levels |
| bus_addr | input | 7 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data, valid while bus_rd is 1, else 0 |
| ei_cmd | input | 1 | Set the global enable |
| di_cmd | input | 1 | Clear the global enable |
| irq_ack | input | 1 | Core accepts the pending interrupt |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vector | output | 12 | Latched vector address |
| entry_busy | output | 1 | Interrupt entry window in progress |
| aux_ctl | output | 1 | Control bit held in 0x078 bit 3 |

## Verification
`bus_rdata` and `irq_req` are combinational, so the bench samples them 1 ns after driving or after a clock edge, in the same cycle. A flag, a mask or the enable state changes on the first rising edge after its stimulus is driven at a falling edge. The bench therefore checks it through a read or through `irq_req` in the following cycle. `irq_vector` and `entry_busy` change on the edge after the acknowledge, and the bench then counts the busy samples edge by edge until the window closes, expecting exactly 12.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int DATA_W       = 4;
    localparam int ADDR_W       = 7;
    localparam int VEC_W        = 12;
    localparam int N_TMR        = 3;
    localparam int N_PIN        = 4;
    localparam int ENTRY_CYCLES = 12;

    localparam logic [ADDR_W-1:0] ADR_PINMSK = 7'h75;
    localparam logic [ADDR_W-1:0] ADR_TMRMSK = 7'h78;
    localparam logic [ADDR_W-1:0] ADR_TMRFLG = 7'h79;
    localparam logic [ADDR_W-1:0] ADR_PINFLG = 7'h7A;

    localparam int PIN_FLAG_BIT = 2;
    localparam int AUX_BIT      = DATA_W - 1;

    localparam logic [VEC_W-1:0] VEC_RESET = 12'h100;
    localparam logic [VEC_W-1:0] VEC_PIN   = 12'h102;
    localparam logic [VEC_W-1:0] VEC_TMR   = 12'h104;
    localparam logic [VEC_W-1:0] VEC_BOTH  = 12'h106;

    typedef enum logic [1:0] {
        SRC_NONE = 2'b00,
        SRC_PIN  = 2'b01,
        SRC_TMR  = 2'b10,
        SRC_BOTH = 2'b11
    } src_e;

    typedef struct packed {
        logic tmr;
        logic pin;
    } pend_t;

    function automatic src_e src_of(pend_t p);
        return src_e'({p.tmr, p.pin});
    endfunction

    function automatic logic [VEC_W-1:0] vec_of(src_e s);
        case (s)
            SRC_PIN:  return VEC_PIN;
            SRC_TMR:  return VEC_TMR;
            SRC_BOTH: return VEC_BOTH;
            default:  return VEC_RESET;
        endcase
    endfunction

endpackage

// File: rtl/irq_edge_flags.sv
module irq_edge_flags
    import irq_pkg::*;
#(
    parameter int NT = N_TMR,
    parameter int NP = N_PIN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NT-1:0] tick,
    input  logic [NP-1:0] pins,
    input  logic [NP-1:0] pin_mask,
    input  logic          clr_tmr,
    input  logic          clr_pin,
    output logic [NT-1:0] tmr_evt,
    output logic          pin_evt,
    output logic [NT-1:0] tmr_flag,
    output logic          pin_flag
);

    logic [NT-1:0] tick_q;
    logic [NP-1:0] pins_q;
    logic [NP-1:0] pin_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
            pins_q <= '0;
        end else begin
            tick_q <= tick;
            pins_q <= pins;
        end
    end

    // one flag per timer source, set on falling tick, set beats clear
    for (genvar i = 0; i < NT; i++) begin : g_tmr
        assign tmr_evt[i] = tick_q[i] & ~tick[i];

        always_ff @(posedge clk) begin
            if (rst)
                tmr_flag[i] <= 1'b0;
            else if (tmr_evt[i])
                tmr_flag[i] <= 1'b1;
            else if (clr_tmr)
                tmr_flag[i] <= 1'b0;
        end
    end

    // per-pin qualified rising edges share one flag
    for (genvar j = 0; j < NP; j++) begin : g_pin
        assign pin_rise[j] = pins[j] & ~pins_q[j] & pin_mask[j];
    end

    assign pin_evt = |pin_rise;

    always_ff @(posedge clk) begin
        if (rst)
            pin_flag <= 1'b0;
        else if (pin_evt)
            pin_flag <= 1'b1;
        else if (clr_pin)
            pin_flag <= 1'b0;
    end

endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int NT = N_TMR,
    parameter int NP = N_PIN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          rd,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic [NT-1:0] tmr_flag,
    input  logic          pin_flag,
    output logic [DW-1:0] rdata,
    output logic [NP-1:0] pin_mask,
    output logic [NT-1:0] tmr_mask,
    output logic          aux_ctl,
    output logic          clr_tmr,
    output logic          clr_pin
);

    logic sel_pinmsk, sel_tmrmsk, sel_tmrflg, sel_pinflg;

    assign sel_pinmsk = (addr == ADR_PINMSK);
    assign sel_tmrmsk = (addr == ADR_TMRMSK);
    assign sel_tmrflg = (addr == ADR_TMRFLG);
    assign sel_pinflg = (addr == ADR_PINFLG);

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_mask <= '0;
            tmr_mask <= '0;
            aux_ctl  <= 1'b0;
        end else if (wr) begin
            if (sel_pinmsk)
                pin_mask <= wdata[NP-1:0];
            if (sel_tmrmsk) begin
                tmr_mask <= wdata[NT-1:0];
                aux_ctl  <= wdata[AUX_BIT];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            if (sel_pinmsk)
                rdata[NP-1:0] = pin_mask;
            if (sel_tmrmsk) begin
                rdata[NT-1:0]  = tmr_mask;
                rdata[AUX_BIT] = aux_ctl;
            end
            if (sel_tmrflg)
                rdata[NT-1:0] = tmr_flag;
            if (sel_pinflg)
                rdata[PIN_FLAG_BIT] = pin_flag;
        end
    end

    assign clr_tmr = rd & sel_tmrflg;
    assign clr_pin = rd & sel_pinflg;

endmodule

// File: rtl/irq_entry.sv
module irq_entry
    import irq_pkg::*;
#(
    parameter int NCYC = ENTRY_CYCLES,
    parameter int VW   = VEC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ei,
    input  logic          di,
    input  logic          ack,
    input  pend_t         pend,
    output logic          req,
    output logic [VW-1:0] vec,
    output logic          busy
);

    localparam int CW = $clog2(NCYC + 1);

    logic          gie;
    logic [CW-1:0] cnt;
    logic          accept;

    assign busy   = (cnt != '0);
    assign req    = gie & (pend.tmr | pend.pin) & ~busy;
    assign accept = ack & req;

    always_ff @(posedge clk) begin
        if (rst)
            gie <= 1'b0;
        else if (accept)
            gie <= 1'b0;
        else if (ei)
            gie <= 1'b1;
        else if (di)
            gie <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            vec <= VW'(VEC_RESET);
        end else if (accept) begin
            cnt <= CW'(NCYC);
            vec <= VW'(vec_of(src_of(pend)));
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int DW   = DATA_W,
    parameter int NP   = N_PIN,
    parameter int VW   = VEC_W,
    parameter int NCYC = ENTRY_CYCLES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_2hz,
    input  logic          tick_8hz,
    input  logic          tick_32hz,
    input  logic [NP-1:0] port_pins,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          ei_cmd,
    input  logic          di_cmd,
    input  logic          irq_ack,
    output logic          irq_req,
    output logic [VW-1:0] irq_vector,
    output logic          entry_busy,
    output logic          aux_ctl
);

    localparam int NT = N_TMR;

    logic [NT-1:0] ticks;
    logic [NT-1:0] tmr_evt, tmr_flag, tmr_mask;
    logic          pin_evt, pin_flag;
    logic [NP-1:0] pin_mask;
    logic          clr_tmr, clr_pin;
    pend_t         pend;

    assign ticks = {tick_2hz, tick_8hz, tick_32hz};

    irq_edge_flags #(.NT(NT), .NP(NP)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .tick     (ticks),
        .pins     (port_pins),
        .pin_mask (pin_mask),
        .clr_tmr  (clr_tmr),
        .clr_pin  (clr_pin),
        .tmr_evt  (tmr_evt),
        .pin_evt  (pin_evt),
        .tmr_flag (tmr_flag),
        .pin_flag (pin_flag)
    );

    irq_regs #(.AW(AW), .DW(DW), .NT(NT), .NP(NP)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .rd       (bus_rd),
        .wr       (bus_wr),
        .wdata    (bus_wdata),
        .tmr_flag (tmr_flag),
        .pin_flag (pin_flag),
        .rdata    (bus_rdata),
        .pin_mask (pin_mask),
        .tmr_mask (tmr_mask),
        .aux_ctl  (aux_ctl),
        .clr_tmr  (clr_tmr),
        .clr_pin  (clr_pin)
    );

    assign pend.tmr = |(tmr_flag & tmr_mask);
    assign pend.pin = pin_flag & (|pin_mask);

    irq_entry #(.NCYC(NCYC), .VW(VW)) u_entry (
        .clk  (clk),
        .rst  (rst),
        .ei   (ei_cmd),
        .di   (di_cmd),
        .ack  (irq_ack),
        .pend (pend),
        .req  (irq_req),
        .vec  (irq_vector),
        .busy (entry_busy)
    );

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
    import irq_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int NT   = N_TMR,
    parameter int VW   = VEC_W,
    parameter int NCYC = ENTRY_CYCLES
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] bus_addr,
    input logic          bus_rd,
    input logic          irq_ack,
    input logic          irq_req,
    input logic [VW-1:0] irq_vector,
    input logic          entry_busy,
    input logic [NT-1:0] tmr_evt,
    input logic [NT-1:0] tmr_flag,
    input logic          pin_evt,
    input logic          pin_flag
);

    int unsigned run;

    always_ff @(posedge clk) begin
        if (rst)
            run <= 0;
        else if (entry_busy)
            run <= run + 1;
        else
            run <= 0;
    end

    // R1
    vec_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_vector == VW'(VEC_RESET)) || (irq_vector == VW'(VEC_PIN)) ||
        (irq_vector == VW'(VEC_TMR))   || (irq_vector == VW'(VEC_BOTH)));

    // R4
    tmr_read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADR_TMRFLG && tmr_evt == '0) |=> (tmr_flag == '0));

    // R5
    pin_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        pin_evt |=> pin_flag);

    for (genvar i = 0; i < NT; i++) begin : g_tchk
        // R5
        tmr_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
            tmr_evt[i] |=> tmr_flag[i]);
    end

    // R9
    accept_drops_req_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_req) |=> !irq_req);

    // R9
    accept_opens_window_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_req) |=> entry_busy);

    // R9
    window_short_chk: assert property (@(posedge clk) disable iff (rst)
        entry_busy |-> (run < NCYC));

    // R9
    window_full_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(entry_busy) |-> (run == NCYC));

    // R10
    idle_ack_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !irq_req && !entry_busy) |=> !entry_busy);

    // R10
    vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        entry_busy |=> $stable(irq_vector));

endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .irq_ack    (irq_ack),
    .irq_req    (irq_req),
    .irq_vector (irq_vector),
    .entry_busy (entry_busy),
    .tmr_evt    (tmr_evt),
    .tmr_flag   (tmr_flag),
    .pin_evt    (pin_evt),
    .pin_flag   (pin_flag)
);

// File: tb/irq_ctrl_bench.sv
`timescale 1ns/1ps
module irq_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NTBL = 17;

    // {req tag, write, addr, wdata, expected read}
    localparam logic [19:0] TBL [NTBL] = '{
        {4'd1, 1'b0, 7'h75, 4'h0, 4'h0},
        {4'd1, 1'b0, 7'h78, 4'h0, 4'h0},
        {4'd1, 1'b0, 7'h79, 4'h0, 4'h0},
        {4'd1, 1'b0, 7'h7A, 4'h0, 4'h0},
        {4'd6, 1'b1, 7'h75, 4'hA, 4'h0},
        {4'd6, 1'b0, 7'h75, 4'h0, 4'hA},
        {4'd6, 1'b1, 7'h78, 4'hF, 4'h0},
        {4'd6, 1'b0, 7'h78, 4'h0, 4'hF},
        {4'd4, 1'b1, 7'h79, 4'hF, 4'h0},
        {4'd4, 1'b0, 7'h79, 4'h0, 4'h0},
        {4'd4, 1'b1, 7'h7A, 4'hF, 4'h0},
        {4'd4, 1'b0, 7'h7A, 4'h0, 4'h0},
        {4'd4, 1'b0, 7'h70, 4'h0, 4'h0},
        {4'd6, 1'b1, 7'h78, 4'h0, 4'h0},
        {4'd6, 1'b0, 7'h78, 4'h0, 4'h0},
        {4'd6, 1'b1, 7'h75, 4'h0, 4'h0},
        {4'd6, 1'b0, 7'h75, 4'h0, 4'h0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_2hz = 1'b0, tick_8hz = 1'b0, tick_32hz = 1'b0;
    logic [3:0]  port_pins = '0;
    logic [6:0]  bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_wdata = '0;
    logic [3:0]  bus_rdata;
    logic        ei_cmd = 1'b0, di_cmd = 1'b0, irq_ack = 1'b0;
    logic        irq_req;
    logic [11:0] irq_vector;
    logic        entry_busy;
    logic        aux_ctl;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    irq_ctrl u_irq_ctrl (
        .clk(clk), .rst(rst),
        .tick_2hz(tick_2hz), .tick_8hz(tick_8hz), .tick_32hz(tick_32hz),
        .port_pins(port_pins),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ei_cmd(ei_cmd), .di_cmd(di_cmd), .irq_ack(irq_ack),
        .irq_req(irq_req), .irq_vector(irq_vector),
        .entry_busy(entry_busy), .aux_ctl(aux_ctl)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [6:0] a, output logic [3:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [6:0] a, input logic [3:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic pulse_ei();
        @(negedge clk); ei_cmd = 1'b1;
        @(posedge clk); #1 ei_cmd = 1'b0;
    endtask

    task automatic pulse_di();
        @(negedge clk); di_cmd = 1'b1;
        @(posedge clk); #1 di_cmd = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); irq_ack = 1'b1;
        @(posedge clk); #1 irq_ack = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [3:0] d;
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state at the ports
        chk("R1 irq_req", int'(irq_req), 0);
        chk("R1 entry_busy", int'(entry_busy), 0);
        chk("R1 irq_vector", int'(irq_vector), 'h100);
        chk("R1 aux_ctl", int'(aux_ctl), 0);

        // register table
        for (int i = 0; i < NTBL; i++) begin
            if (TBL[i][15]) begin
                wr(TBL[i][14:8], TBL[i][7:4]);
            end else begin
                rd(TBL[i][14:8], d);
                chk($sformatf("R%0d table entry %0d", TBL[i][19:16], i),
                    int'(d), int'(TBL[i][3:0]));
            end
        end

        // R6 control bit drives aux_ctl
        wr(7'h78, 4'h8);
        chk("R6 aux_ctl set", int'(aux_ctl), 1);
        wr(7'h78, 4'h0);
        chk("R6 aux_ctl clear", int'(aux_ctl), 0);

        // R2 rising tick sets nothing, falling tick sets flag
        @(negedge clk); tick_8hz = 1'b1;
        rd(7'h79, d);
        chk("R2 rising edge ignored", int'(d), 0);
        @(negedge clk); tick_8hz = 1'b0;
        rd(7'h79, d);
        chk("R2 8hz flag bit1", int'(d), 2);
        rd(7'h79, d);
        chk("R4 flags cleared by read", int'(d), 0);
        @(negedge clk); tick_2hz = 1'b1; tick_32hz = 1'b1;
        @(negedge clk); tick_2hz = 1'b0; tick_32hz = 1'b0;
        rd(7'h79, d);
        chk("R2 2hz and 32hz flags", int'(d), 5);
        rd(7'h79, d);
        chk("R4 both cleared", int'(d), 0);

        // R5 set edge in the same cycle as a clearing read
        @(negedge clk); tick_2hz = 1'b1;
        @(negedge clk);
        tick_2hz = 1'b0;
        bus_addr = 7'h79;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        chk("R5 read before set", int'(d), 0);
        @(posedge clk); #1 bus_rd = 1'b0;
        rd(7'h79, d);
        chk("R5 flag survives read", int'(d), 4);

        // R3 pin masking
        wr(7'h75, 4'h1);
        @(negedge clk); port_pins = 4'b0010;
        rd(7'h7A, d);
        chk("R3 unmasked pin ignored", int'(d), 0);
        @(negedge clk); port_pins = 4'b0011;
        rd(7'h7A, d);
        chk("R3 masked pin sets bit2", int'(d), 4);
        rd(7'h7A, d);
        chk("R4 pin flag cleared", int'(d), 0);
        @(negedge clk); port_pins = 4'b0000;
        rd(7'h7A, d);
        chk("R3 falling pin ignored", int'(d), 0);

        // R7 request gating by enable
        wr(7'h78, 4'h4);
        @(negedge clk); tick_2hz = 1'b1;
        @(negedge clk); tick_2hz = 1'b0;
        @(posedge clk); #1;
        chk("R7 no req while disabled", int'(irq_req), 0);
        pulse_ei();
        chk("R8 ei raises req", int'(irq_req), 1);
        pulse_di();
        chk("R8 di drops req", int'(irq_req), 0);
        pulse_ei();
        chk("R8 ei raises req again", int'(irq_req), 1);

        // R9 timer acknowledge
        pulse_ack();
        chk("R9 req dropped after ack", int'(irq_req), 0);
        chk("R9 timer vector", int'(irq_vector), 'h104);
        n = 0;
        while (entry_busy && n < 50) begin
            n++;
            @(posedge clk); #1;
        end
        chk("R9 entry window length", n, 12);
        pulse_ei();
        chk("R8 uncleared flag re-requests", int'(irq_req), 1);
        rd(7'h79, d);
        chk("R4 read returns 2hz flag", int'(d), 4);
        #1;
        chk("R7 req drops once flag cleared", int'(irq_req), 0);

        // R10 ack with nothing pending
        pulse_ack();
        chk("R10 idle ack no window", int'(entry_busy), 0);
        chk("R10 idle ack keeps vector", int'(irq_vector), 'h104);

        // R9 pin acknowledge
        @(negedge clk); port_pins = 4'b0001;
        @(posedge clk); #1;
        chk("R7 pin request", int'(irq_req), 1);
        pulse_ack();
        chk("R9 pin vector", int'(irq_vector), 'h102);
        chk("R9 pin window open", int'(entry_busy), 1);
        repeat (13) @(negedge clk);
        rd(7'h7A, d);
        @(negedge clk); port_pins = 4'b0000;

        // R9 both classes pending
        @(negedge clk); tick_2hz = 1'b1;
        @(negedge clk); tick_2hz = 1'b0; port_pins = 4'b0001;
        pulse_ei();
        chk("R7 combined request", int'(irq_req), 1);
        pulse_ack();
        chk("R9 combined vector", int'(irq_vector), 'h106);
        repeat (13) @(negedge clk);
        chk("R9 window closed", int'(entry_busy), 0);
        rd(7'h79, d);
        rd(7'h7A, d);

        finish_run();
    end

endmodule